// File: doc/BRIEF.md
# Path-Routed Control Packet Switch

This block joins one upstream byte-wide stream link to a parameterised number of downstream stream links. Every link uses AXI4-Stream style valid/ready/last handshakes. All links share one clock and an active-high synchronous reset. Each packet carries a short routing path in front of a type byte and a payload.

Traffic going down is steered by the first hop of the path, and that hop is removed. Traffic coming up gets the index of its arrival port added to the front of its path. The upstream output is shared by all downstream inputs and by a local identification responder. It is handed out round-robin, one whole packet per grant. A request with an empty path and the identify type is answered by the switch itself with a fixed 32-byte descriptor.

Top module: `path_switch`

## Requirements
- R1: A packet is a length byte L (0 to 15, upper nibble zero), then L path bytes, then a type byte, then the payload up to tlast. An upstream packet with L of at least 1 and first hop k below PORTS comes out whole on downstream output k. On the way out its length byte is L-1, the first hop is removed, and every later byte is unchanged. Packets arriving on one input leave in the order they arrived.
- R2: An upstream packet whose first hop is PORTS or more is consumed and appears on no output. An empty-path packet whose type is not 0xFE is also consumed and appears on no output.
- R3: A packet on downstream input k with length byte L below 15 comes out on the upstream output with length byte L+1. It is followed by the byte k, and then by the original path, type and payload, unchanged.
- R4: A downstream packet whose length byte is 15 is consumed and appears on no output.
- R5: An upstream packet with L=0 and type 0xFE is answered on the upstream output with a 34-byte frame, with tlast on the final byte. The frame is length 0, then type 0xFF, then 32 payload bytes. The payload is ID_CODE (high byte first), then PORTS, then the 29 bytes of ID_NAME (most significant byte first).
- R6: The upstream output serves the requesters (downstream inputs 0..PORTS-1 and the responder as number PORTS) round-robin. The search starts just after the last one served. A grant lasts until the tlast of that packet, so packets never interleave.
- R7: While any output has tvalid high and tready low, its tvalid, tdata and tlast stay unchanged in the next cycle. No byte is lost or duplicated under backpressure or source idle cycles.
- R8: During and right after reset, no output has tvalid high.
- R9: At most one downstream output is valid at a time, and at most one downstream input sees tready high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_in_tdata | input | 8 | Upstream input byte |
| up_in_tvalid | input | 1 | Upstream input valid |
| up_in_tready | output | 1 | Upstream input ready |
| up_in_tlast | input | 1 | Upstream input last byte |
| up_out_tdata | output | 8 | Upstream output byte |
| up_out_tvalid | output | 1 | Upstream output valid |
| up_out_tready | input | 1 | Upstream output ready |
| up_out_tlast | output | 1 | Upstream output last byte |
| dn_in_tdata | input | 8*PORTS | Downstream input bytes, port k at bits 8k+7:8k |
| dn_in_tvalid | input | PORTS | Downstream input valids |
| dn_in_tready | output | PORTS | Downstream input readies |
| dn_in_tlast | input | PORTS | Downstream input last flags |
| dn_out_tdata | output | 8*PORTS | Downstream output bytes, port k at bits 8k+7:8k |
| dn_out_tvalid | output | PORTS | Downstream output valids |
| dn_out_tready | input | PORTS | Downstream output readies |
| dn_out_tlast | output | PORTS | Downstream output last flags |

## Verification
The assertions assume that length bytes keep their upper nibble at zero. They also assume that no second identify request arrives while a reply is still owed, because pending requests merge into one. The stimulus builds every frame with lengths up to 15 and issues at most one identify request per phase, draining the switch before the next phase. Sources keep valid and data steady until accepted. Idle and backpressure are drawn from $urandom with a one-in-four pass rate in the stressed phases.

// File: rtl/path_switch.sv
module path_switch #(
  parameter int PORTS = 4,
  parameter logic [15:0] ID_CODE = 16'h5A17,
  parameter logic [231:0] ID_NAME = {"PKTSWITCH", {20{8'h00}}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         up_in_tdata,
  input  logic               up_in_tvalid,
  output logic               up_in_tready,
  input  logic               up_in_tlast,
  output logic [7:0]         up_out_tdata,
  output logic               up_out_tvalid,
  input  logic               up_out_tready,
  output logic               up_out_tlast,
  input  logic [8*PORTS-1:0] dn_in_tdata,
  input  logic [PORTS-1:0]   dn_in_tvalid,
  output logic [PORTS-1:0]   dn_in_tready,
  input  logic [PORTS-1:0]   dn_in_tlast,
  output logic [8*PORTS-1:0] dn_out_tdata,
  output logic [PORTS-1:0]   dn_out_tvalid,
  input  logic [PORTS-1:0]   dn_out_tready,
  output logic [PORTS-1:0]   dn_out_tlast
);
  localparam int NSRC = PORTS + 1;
  localparam int SW = $clog2(NSRC);
  localparam int PW = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int IDLAST = 33;

  typedef enum logic [2:0] {D_LEN, D_HOP, D_FWD, D_TYPE, D_SKIP} dstate_t;
  typedef enum logic [2:0] {U_IDLE, U_LEN, U_IDX, U_BODY, U_SKIP, U_ID} ustate_t;

  // downward path
  dstate_t ds;
  logic [3:0] dlen;
  logic [PW-1:0] dsel;
  logic [7:0] dd;
  logic dv, dl, idreq, id_pend;
  logic dfree, dfire, id_set;

  assign dfree = !dv || dn_out_tready[dsel];
  assign up_in_tready = (ds == D_HOP || ds == D_FWD) ? dfree : 1'b1;
  assign dfire = up_in_tvalid && up_in_tready;
  assign id_set = dfire && up_in_tlast &&
                  ((ds == D_TYPE && up_in_tdata == 8'hFE) || (ds == D_SKIP && idreq));
  assign dn_out_tvalid = dv ? (PORTS'(1) << dsel) : '0;
  assign dn_out_tdata = {PORTS{dd}};
  assign dn_out_tlast = {PORTS{dl}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ds <= D_LEN;
      dv <= 1'b0;
      dl <= 1'b0;
      dd <= '0;
      dsel <= '0;
      dlen <= '0;
      idreq <= 1'b0;
    end else begin
      if (dv && dn_out_tready[dsel]) dv <= 1'b0;
      if (dfire) begin
        case (ds)
          D_LEN: begin
            dlen <= up_in_tdata[3:0];
            idreq <= 1'b0;
            if (up_in_tlast) ds <= D_LEN;
            else ds <= (up_in_tdata[3:0] == 4'd0) ? D_TYPE : D_HOP;
          end
          D_HOP: begin
            idreq <= 1'b0;
            if (up_in_tdata < 8'(PORTS)) begin
              dsel <= up_in_tdata[PW-1:0];
              dd <= {4'h0, dlen - 4'd1};
              dl <= up_in_tlast;
              dv <= 1'b1;
              ds <= up_in_tlast ? D_LEN : D_FWD;
            end else begin
              ds <= up_in_tlast ? D_LEN : D_SKIP;
            end
          end
          D_FWD: begin
            dd <= up_in_tdata;
            dl <= up_in_tlast;
            dv <= 1'b1;
            if (up_in_tlast) ds <= D_LEN;
          end
          D_TYPE: begin
            idreq <= (up_in_tdata == 8'hFE);
            ds <= up_in_tlast ? D_LEN : D_SKIP;
          end
          default: if (up_in_tlast) ds <= D_LEN;
        endcase
      end
    end
  end

  // upward path
  ustate_t us;
  logic [SW-1:0] g, ptr, pick, nxt;
  logic [PW-1:0] gp;
  logic [5:0] cnt;
  logic [7:0] ud, gd, idb;
  logic uv, ul, ufree, gv, gl, rd, take, found;
  logic [NSRC-1:0] req;

  assign req = {id_pend, dn_in_tvalid};
  assign ufree = !uv || up_out_tready;
  assign gp = (g < SW'(PORTS)) ? PW'(g) : '0;
  assign gv = dn_in_tvalid[gp];
  assign gl = dn_in_tlast[gp];
  assign gd = dn_in_tdata[gp*8 +: 8];
  assign rd = ((us == U_LEN || us == U_BODY) && ufree) || us == U_SKIP;
  assign take = rd && gv;
  assign dn_in_tready = rd ? (PORTS'(1) << gp) : '0;
  assign nxt = (g == SW'(PORTS)) ? '0 : g + 1'b1;
  assign up_out_tdata = ud;
  assign up_out_tvalid = uv;
  assign up_out_tlast = ul;

  always_comb begin
    int idx;
    pick = ptr;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      idx = (int'(ptr) + i) % NSRC;
      if (!found && req[idx]) begin
        found = 1'b1;
        pick = SW'(idx);
      end
    end
  end

  always_comb begin
    if (cnt == 6'd0) idb = 8'h00;
    else if (cnt == 6'd1) idb = 8'hFF;
    else if (cnt == 6'd2) idb = ID_CODE[15:8];
    else if (cnt == 6'd3) idb = ID_CODE[7:0];
    else if (cnt == 6'd4) idb = 8'(PORTS);
    else idb = ID_NAME[8*(IDLAST - int'(cnt)) +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      us <= U_IDLE;
      g <= '0;
      ptr <= '0;
      cnt <= '0;
      uv <= 1'b0;
      ul <= 1'b0;
      ud <= '0;
      id_pend <= 1'b0;
    end else begin
      if (uv && up_out_tready) uv <= 1'b0;
      case (us)
        U_IDLE: if (found) begin
          g <= pick;
          cnt <= '0;
          us <= (pick == SW'(PORTS)) ? U_ID : U_LEN;
          if (pick == SW'(PORTS)) id_pend <= 1'b0;
        end
        U_LEN: if (take) begin
          if (gd[3:0] == 4'hF || gl) begin
            us <= gl ? U_IDLE : U_SKIP;
            if (gl) ptr <= nxt;
          end else begin
            ud <= {4'h0, gd[3:0] + 4'd1};
            ul <= 1'b0;
            uv <= 1'b1;
            us <= U_IDX;
          end
        end
        U_IDX: if (ufree) begin
          ud <= 8'(g);
          ul <= 1'b0;
          uv <= 1'b1;
          us <= U_BODY;
        end
        U_BODY: if (take) begin
          ud <= gd;
          ul <= gl;
          uv <= 1'b1;
          if (gl) begin
            us <= U_IDLE;
            ptr <= nxt;
          end
        end
        U_SKIP: if (take && gl) begin
          us <= U_IDLE;
          ptr <= nxt;
        end
        default: if (ufree) begin
          ud <= idb;
          ul <= (cnt == 6'(IDLAST));
          uv <= 1'b1;
          cnt <= cnt + 6'd1;
          if (cnt == 6'(IDLAST)) begin
            us <= U_IDLE;
            ptr <= nxt;
          end
        end
      endcase
      if (id_set) id_pend <= 1'b1;
    end
  end

  assert_up_hold_R7: assert property (@(posedge clk) disable iff (rst)
    up_out_tvalid && !up_out_tready |=>
      up_out_tvalid && $stable(up_out_tdata) && $stable(up_out_tlast));
  assert_dn_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_out_tvalid & ~dn_out_tready) != '0 |=>
      $stable(dn_out_tvalid) && $stable(dn_out_tdata) && $stable(dn_out_tlast));
  assert_dn_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_out_tvalid));
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dn_in_tready));
  assert_grant_held_R6: assert property (@(posedge clk) disable iff (rst)
    us == U_BODY && !(take && gl) |=> us == U_BODY && $stable(g));
  assert_id_len_R5: assert property (@(posedge clk) disable iff (rst)
    us == U_ID |-> cnt <= 6'(IDLAST));
endmodule

// File: tb/path_switch_tb.sv
module path_switch_tb_top;
  localparam int P = 4;
  localparam logic [15:0] CODE = 16'hC3A5;
  localparam logic [231:0] NAME = {"ROUTER-X", {21{8'h00}}};

  logic clk = 0, rst = 1;
  always #10 clk = ~clk;

  logic [7:0] up_in_tdata = 0, up_out_tdata;
  logic up_in_tvalid = 0, up_in_tready, up_in_tlast = 0;
  logic up_out_tvalid, up_out_tready = 1, up_out_tlast;
  logic [8*P-1:0] dn_in_tdata = 0, dn_out_tdata;
  logic [P-1:0] dn_in_tvalid = 0, dn_in_tready, dn_in_tlast = 0;
  logic [P-1:0] dn_out_tvalid, dn_out_tready = '1, dn_out_tlast;

  path_switch #(.PORTS(P), .ID_CODE(CODE), .ID_NAME(NAME)) dut_i (.*);

  int checks = 0, errors = 0, stall_err = 0, oh_err = 0;
  bit done = 0, bp = 0, idl = 0;
  logic [8:0] up_tx[$];
  logic [8:0] dn_tx[P][$];
  logic [8:0] exp_dn[P][$];
  logic [8:0] exp_up[P+1][$];
  logic [8:0] ubuf[$];
  int order[$];
  bit up_fired;
  bit [P-1:0] dn_fired;
  bit dn_bad[P];
  int dn_act[P], dn_exp[P];
  bit pu_st, pd_st[P];
  logic [8:0] pu_d, pd_d[P];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void send_down(int hop, int extra, int plen, logic [7:0] typ);
    logic [7:0] b[$];
    logic [7:0] e[$];
    logic [7:0] x;
    b.push_back(8'(1 + extra)); b.push_back(8'(hop)); e.push_back(8'(extra));
    for (int i = 0; i < extra; i++) begin x = 8'($urandom); b.push_back(x); e.push_back(x); end
    b.push_back(typ); e.push_back(typ);
    for (int i = 0; i < plen; i++) begin x = 8'($urandom); b.push_back(x); e.push_back(x); end
    foreach (b[i]) up_tx.push_back({i == b.size() - 1, b[i]});
    if (hop < P) foreach (e[i]) exp_dn[hop].push_back({i == e.size() - 1, e[i]});
  endfunction

  function automatic void send_up(int k, int len, int plen, logic [7:0] typ);
    logic [7:0] b[$];
    logic [7:0] e[$];
    logic [7:0] x;
    b.push_back(8'(len)); e.push_back(8'(len + 1)); e.push_back(8'(k));
    for (int i = 0; i < len; i++) begin x = 8'($urandom); b.push_back(x); e.push_back(x); end
    b.push_back(typ); e.push_back(typ);
    for (int i = 0; i < plen; i++) begin x = 8'($urandom); b.push_back(x); e.push_back(x); end
    foreach (b[i]) dn_tx[k].push_back({i == b.size() - 1, b[i]});
    if (len < 15) foreach (e[i]) exp_up[k].push_back({i == e.size() - 1, e[i]});
  endfunction

  function automatic logic [7:0] id_byte(int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    if (i == 2) return CODE[15:8];
    if (i == 3) return CODE[7:0];
    if (i == 4) return 8'(P);
    return NAME[8*(28 - (i - 5)) +: 8];
  endfunction

  function automatic void send_id(int extra);
    up_tx.push_back({extra == 0 ? 1'b0 : 1'b0, 8'h00});
    up_tx.push_back({extra == 0, 8'hFE});
    for (int i = 0; i < extra; i++) up_tx.push_back({i == extra - 1, 8'($urandom)});
    for (int i = 0; i < 34; i++) exp_up[P].push_back({i == 33, id_byte(i)});
  endfunction

  always @(posedge clk) begin
    if (up_in_tvalid && up_in_tready) begin void'(up_tx.pop_front()); up_fired = 1; end
    for (int k = 0; k < P; k++)
      if (dn_in_tvalid[k] && dn_in_tready[k]) begin void'(dn_tx[k].pop_front()); dn_fired[k] = 1; end
    if (!rst) begin
      if ($countones(dn_out_tvalid) > 1 || $countones(dn_in_tready) > 1) oh_err++;
      if (pu_st && (!up_out_tvalid || {up_out_tlast, up_out_tdata} != pu_d)) stall_err++;
      pu_st = up_out_tvalid && !up_out_tready; pu_d = {up_out_tlast, up_out_tdata};
      for (int k = 0; k < P; k++) begin
        if (pd_st[k] && (!dn_out_tvalid[k] || {dn_out_tlast[k], dn_out_tdata[k*8 +: 8]} != pd_d[k]))
          stall_err++;
        pd_st[k] = dn_out_tvalid[k] && !dn_out_tready[k];
        pd_d[k] = {dn_out_tlast[k], dn_out_tdata[k*8 +: 8]};
        if (dn_out_tvalid[k] && dn_out_tready[k]) begin
          if (exp_dn[k].size() == 0) chk(0, "R2", "unexpected downstream byte on port", k, -1);
          else begin
            logic [8:0] e;
            e = exp_dn[k].pop_front();
            if (e != {dn_out_tlast[k], dn_out_tdata[k*8 +: 8]} && !dn_bad[k]) begin
              dn_bad[k] = 1; dn_act[k] = {dn_out_tlast[k], dn_out_tdata[k*8 +: 8]}; dn_exp[k] = e;
            end
            if (dn_out_tlast[k]) begin
              chk(!dn_bad[k], "R1", "downstream frame byte (last,data)", dn_act[k], dn_exp[k]);
              dn_bad[k] = 0;
            end
          end
        end
      end
      if (up_out_tvalid && up_out_tready) begin
        ubuf.push_back({up_out_tlast, up_out_tdata});
        if (up_out_tlast) begin
          int src; bit bad; int a, x;
          src = (ubuf[0][7:0] == 0) ? P : (ubuf.size() > 1 ? int'(ubuf[1][7:0]) : 99);
          bad = 0; a = 0; x = 0;
          if (src > P) chk(0, "R3", "upstream frame source index", src, P);
          else begin
            order.push_back(src);
            foreach (ubuf[i]) begin
              logic [8:0] e;
              e = (exp_up[src].size() > 0) ? exp_up[src].pop_front() : 9'h1FF;
              if (e != ubuf[i] && !bad) begin bad = 1; a = ubuf[i]; x = e; end
            end
            chk(!bad, src == P ? "R5" : "R3", "upstream frame byte (last,data)", a, x);
          end
          ubuf.delete();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!(up_in_tvalid && !up_fired)) begin
      if (up_tx.size() > 0 && (!idl || $urandom % 4 == 0)) begin
        up_in_tvalid <= 1; {up_in_tlast, up_in_tdata} <= up_tx[0];
      end else up_in_tvalid <= 0;
    end
    up_fired = 0;
    for (int k = 0; k < P; k++) begin
      if (!(dn_in_tvalid[k] && !dn_fired[k])) begin
        if (dn_tx[k].size() > 0 && (!idl || $urandom % 4 == 0)) begin
          dn_in_tvalid[k] <= 1; {dn_in_tlast[k], dn_in_tdata[k*8 +: 8]} <= dn_tx[k][0];
        end else dn_in_tvalid[k] <= 0;
      end
      dn_out_tready[k] <= bp ? ($urandom % 4 == 0) : 1'b1;
    end
    dn_fired = '0;
    up_out_tready <= bp ? ($urandom % 4 == 0) : 1'b1;
  end

  function automatic bit all_empty();
    bit r;
    r = up_tx.size() == 0 && ubuf.size() == 0 && exp_up[P].size() == 0;
    for (int k = 0; k < P; k++)
      r = r && dn_tx[k].size() == 0 && exp_dn[k].size() == 0 && exp_up[k].size() == 0;
    return r;
  endfunction

  task automatic drain(string req);
    int q = 0;
    for (int i = 0; i < 20000 && q < 40; i++) begin
      @(negedge clk);
      if (all_empty() && !up_out_tvalid && dn_out_tvalid == 0) q++; else q = 0;
    end
    chk(all_empty(), req, "all expected frames delivered", 0, 1 - int'(all_empty()));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run ended by timeout", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd777));
    repeat (3) @(negedge clk);
    chk(!up_out_tvalid && dn_out_tvalid == 0, "R8", "valid outputs in reset", int'(dn_out_tvalid), 0);
    rst = 0;
    @(negedge clk);
    chk(!up_out_tvalid && dn_out_tvalid == 0, "R8", "valid outputs after reset", int'(dn_out_tvalid), 0);
    for (int k = 0; k < P; k++) send_down(k, 0, 8, 8'h01);
    drain("R1");
    send_down(2, 3, 4, 8'h21); send_down(0, 14, 0, 8'h07); send_down(3, 1, 1, 8'h00);
    drain("R1");
    send_down(P, 0, 3, 8'h01); send_down(200, 1, 2, 8'h01); send_down(1, 0, 2, 8'h09);
    up_tx.push_back(9'h000); up_tx.push_back(9'h033); up_tx.push_back(9'h155);
    drain("R2");
    for (int k = 0; k < P; k++) begin send_up(k, 0, 8, 8'h01); send_up(k, 2, 3, 8'h44); end
    drain("R3");
    send_up(2, 15, 3, 8'h01); send_up(2, 14, 2, 8'h02); send_up(1, 15, 0, 8'h03);
    drain("R4");
    send_id(0);
    drain("R5");
    send_id(3);
    drain("R5");
    order.delete();
    for (int k = 0; k < P; k++) begin send_up(k, 1, 5, 8'h10); send_up(k, 0, 2, 8'h11); end
    drain("R6");
    chk(order.size() == 2 * P, "R6", "frames in arbitration burst", order.size(), 2 * P);
    for (int i = 1; i < order.size(); i++)
      chk(order[i] == (order[i-1] + 1) % P, "R6", "round-robin successor", order[i], (order[i-1] + 1) % P);
    order.delete();
    send_up(3, 0, 1, 8'h01); send_id(0); send_up(0, 0, 1, 8'h01); send_up(1, 0, 1, 8'h01);
    drain("R6");
    for (int r = 0; r < 4; r++) begin
      bp = (r != 0); idl = (r >= 2);
      for (int n = 0; n < 30; n++) begin
        int c;
        c = $urandom % 4;
        if (c == 0) send_down($urandom % (P + 1), $urandom % 3, $urandom % 9, 8'($urandom));
        else if (c == 1) send_down($urandom % P, $urandom % 15, $urandom % 4, 8'($urandom));
        else send_up($urandom % P, ($urandom % 8 == 0) ? 15 : $urandom % 4, $urandom % 9, 8'($urandom));
      end
      send_id(r);
      drain("R7");
    end
    bp = 0; idl = 0;
    chk(stall_err == 0, "R7", "outputs changed while stalled", stall_err, 0);
    chk(oh_err == 0, "R9", "multiple valid outputs or ready inputs", oh_err, 0);
    finish_run();
  end
endmodule